// File: doc/BRIEF.md
# SAR ADC serial interface controller

This block is the converter-side digital control for a 12-bit successive-approximation ADC behind a three-wire serial port. An active-low select input starts a frame: its falling edge ends acquisition and holds the sample. The serial clock then moves the conversion forward. On each rising clock edge the block presents a trial code to the capacitor DAC and takes one comparator decision into the result register. On each falling edge it moves the next bit onto the serial output, so a bit leaves the block on the edge right after it has been decided.

A full frame has sixteen clock cycles. The output shows a zero first, then the twelve result bits with the most significant bit first, then two zeros, and it is released to high impedance in the sixteenth cycle. A host may also run fourteen-clock frames, which release select before the output would float. The falling edge count at the moment select rises sets the power state. An early release aborts the conversion and powers the converter down. A later release keeps it awake. Waking needs one frame whose data is discarded.

Top module: `sar_serial_ctrl`

## Requirements
- R1: After reset, and whenever `cs_n` is high, `dout_oe` is 0 and `dout` is 0. `pwr_down` is 0 after reset.
- R2: When `cs_n` falls, `dout_oe` goes to 1 at once and `dout` shows a leading 0 until the first `sclk` falling edge.
- R3: After the k-th `sclk` falling edge of a frame (k = 1..12), `dout` carries result bit 12−k (most significant first) with `dout_oe` = 1. The result is the straight-binary code found by the search, where `cmp_hi` = 1 means the input is at or above `trial_code`.
- R4: After the 13th and 14th falling edges, `dout` is 0 and `dout_oe` is 1.
- R5: After the 15th falling edge of a frame, `dout_oe` is 0 and `dout` is 0 for the rest of that frame.
- R6: In a fourteen-clock frame, where `cs_n` rises after the 14th falling edge, `dout_oe` stays 1 for the whole frame and the converter stays awake.
- R7: If `cs_n` rises after k falling edges with 2 ≤ k ≤ 9, the frame is aborted, `dout_oe` drops, and `pwr_down` becomes 1.
- R8: If `cs_n` rises after fewer than 2 falling edges, `pwr_down` keeps its value.
- R9: If `cs_n` rises after 10 or more falling edges, `pwr_down` becomes 0. From power-down, such a frame is the dummy wake frame, and the frame after it carries a valid result.
- R10: `track_en` is 1 exactly while `cs_n` is high and the converter is not powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; rising edges decide bits, falling edges shift them out |
| cs_n | input | 1 | Active-low select; falling edge samples, rising edge ends the frame |
| cmp_hi | input | 1 | Comparator decision for the current trial code |
| trial_code | output | RES_W | Trial code driven to the capacitor DAC |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Output driver enable for `dout` (0 = high impedance) |
| track_en | output | 1 | Sample-and-hold tracking enable |
| pwr_down | output | 1 | Converter power-down state |

## Verification
A wrong bit register or a misaligned step counter appears on `dout` on the very next falling edge. The sweep compares all 4096 codes bit by bit, so any slip of one step shows up as a shifted or repeated bit within the same frame. A frame counter off by one moves the high-impedance point or the abort/wake threshold by one edge. To catch this, the bench releases select after every edge count from 0 to 16, from both power states, and reads `pwr_down` and `track_en` one clock after each release.

// File: rtl/sar_ctrl_pkg.sv
`timescale 1ns/1ps
package sar_ctrl_pkg;

   typedef enum logic {
      PS_AWAKE  = 1'b0,
      PS_ASLEEP = 1'b1
   } pwr_state_t;

   typedef enum logic [1:0] {
      REL_EARLY = 2'd0,
      REL_ABORT = 2'd1,
      REL_FULL  = 2'd2
   } release_t;

   // Classify a select release by the number of falling edges seen in the frame
   function automatic release_t classify_release(input int unsigned edges,
                                                 input int unsigned abort_at,
                                                 input int unsigned wake_at);
      if (edges < abort_at)     return REL_EARLY;
      else if (edges < wake_at) return REL_ABORT;
      else                      return REL_FULL;
   endfunction

endpackage

// File: rtl/sar_edge_cnt.sv
`timescale 1ns/1ps
module sar_edge_cnt #(
   parameter int CNT_W   = 4,
   parameter bit FALLING = 1'b0
) (
   input  logic             clk,
   input  logic             clr,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic [CNT_W-1:0] nxt;
   assign nxt = (count == CMAX) ? count : count + 1'b1;

   generate
      if (FALLING) begin : g_neg
         always_ff @(negedge clk or posedge clr) begin
            if (clr) count <= '0;
            else     count <= nxt;
         end
      end else begin : g_pos
         always_ff @(posedge clk or posedge clr) begin
            if (clr) count <= '0;
            else     count <= nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/sar_decide.sv
`timescale 1ns/1ps
module sar_decide #(
   parameter int RES_W = 12,
   parameter int CNT_W = 4
) (
   input  logic             sclk,
   input  logic             clr,
   input  logic [CNT_W-1:0] rise_cnt,
   input  logic             cmp_hi,
   output logic [RES_W-1:0] result,
   output logic [RES_W-1:0] trial
);
   generate
      for (genvar i = 0; i < RES_W; i++) begin : g_bit
         localparam logic [CNT_W-1:0] STEP = CNT_W'(RES_W - 1 - i);
         logic bit_q;
         logic active;
         assign active = (rise_cnt == STEP);
         always_ff @(posedge sclk or posedge clr) begin
            if (clr)         bit_q <= 1'b0;
            else if (active) bit_q <= cmp_hi;
         end
         assign result[i] = bit_q;
         assign trial[i]  = bit_q | active;
      end
   endgenerate
endmodule

// File: rtl/sar_shift_out.sv
`timescale 1ns/1ps
module sar_shift_out #(
   parameter int RES_W       = 12,
   parameter int CNT_W       = 4,
   parameter int FRAME_EDGES = 15
) (
   input  logic             sclk,
   input  logic             clr,
   input  logic [CNT_W-1:0] fall_cnt,
   input  logic [RES_W-1:0] result,
   output logic             dout,
   output logic             dout_oe
);
   localparam logic [CNT_W-1:0] HIZ_CNT = CNT_W'(FRAME_EDGES);

   logic [RES_W-1:0] aligned;
   assign aligned = result << fall_cnt;

   always_ff @(negedge sclk or posedge clr) begin
      if (clr) dout <= 1'b0;
      else     dout <= aligned[RES_W-1];
   end

   assign dout_oe = ~clr & (fall_cnt < HIZ_CNT);
endmodule

// File: rtl/sar_power_ctl.sv
`timescale 1ns/1ps
module sar_power_ctl
   import sar_ctrl_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter int ABORT_EDGE = 2,
   parameter int WAKE_EDGE  = 10
) (
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic [CNT_W-1:0] fall_cnt,
   output logic             pwr_down
);
   pwr_state_t state;
   release_t   rel;

   assign rel = classify_release(32'(fall_cnt), ABORT_EDGE, WAKE_EDGE);

   always_ff @(posedge cs_n or negedge rst_n) begin
      if (!rst_n) begin
         state <= PS_AWAKE;
      end else begin
         unique case (rel)
            REL_ABORT: state <= PS_ASLEEP;
            REL_FULL:  state <= PS_AWAKE;
            default:   state <= state;
         endcase
      end
   end

   assign pwr_down = (state == PS_ASLEEP);
endmodule

// File: rtl/sar_serial_ctrl.sv
`timescale 1ns/1ps
module sar_serial_ctrl #(
   parameter int RES_W       = 12,
   parameter int TRAIL_ZEROS = 2,
   parameter int ABORT_EDGE  = 2,
   parameter int WAKE_EDGE   = 10
) (
   input  logic             rst_n,
   input  logic             sclk,
   input  logic             cs_n,
   input  logic             cmp_hi,
   output logic [RES_W-1:0] trial_code,
   output logic             dout,
   output logic             dout_oe,
   output logic             track_en,
   output logic             pwr_down
);
   localparam int FRAME_EDGES = RES_W + 1 + TRAIL_ZEROS;
   localparam int CNT_W       = $clog2(FRAME_EDGES + 1);

   generate
      if (RES_W < 2) begin : g_bad_res
         $error("RES_W must be at least 2");
      end
      if (ABORT_EDGE < 1 || WAKE_EDGE <= ABORT_EDGE || WAKE_EDGE > FRAME_EDGES) begin : g_bad_edges
         $error("edge thresholds must satisfy 1 <= ABORT_EDGE < WAKE_EDGE <= frame length");
      end
   endgenerate

   logic             frame_clr;
   logic [CNT_W-1:0] rise_cnt;
   logic [CNT_W-1:0] fall_cnt;
   logic [RES_W-1:0] result;

   assign frame_clr = cs_n | ~rst_n;

   sar_edge_cnt #(.CNT_W(CNT_W), .FALLING(1'b0)) u_rise_cnt (
      .clk(sclk), .clr(frame_clr), .count(rise_cnt));

   sar_edge_cnt #(.CNT_W(CNT_W), .FALLING(1'b1)) u_fall_cnt (
      .clk(sclk), .clr(frame_clr), .count(fall_cnt));

   sar_decide #(.RES_W(RES_W), .CNT_W(CNT_W)) u_decide (
      .sclk(sclk), .clr(frame_clr), .rise_cnt(rise_cnt), .cmp_hi(cmp_hi),
      .result(result), .trial(trial_code));

   sar_shift_out #(.RES_W(RES_W), .CNT_W(CNT_W), .FRAME_EDGES(FRAME_EDGES)) u_shift (
      .sclk(sclk), .clr(frame_clr), .fall_cnt(fall_cnt), .result(result),
      .dout(dout), .dout_oe(dout_oe));

   sar_power_ctl #(.CNT_W(CNT_W), .ABORT_EDGE(ABORT_EDGE), .WAKE_EDGE(WAKE_EDGE)) u_power (
      .rst_n(rst_n), .cs_n(cs_n), .fall_cnt(fall_cnt), .pwr_down(pwr_down));

   assign track_en = cs_n & ~pwr_down;
endmodule

// File: rtl/sar_serial_ctrl_chk.sv
`timescale 1ns/1ps
module sar_serial_ctrl_chk #(
   parameter int FRAME_EDGES = 15,
   parameter int ABORT_EDGE  = 2,
   parameter int WAKE_EDGE   = 10
) (
   input logic rst_n,
   input logic sclk,
   input logic cs_n,
   input logic dout,
   input logic dout_oe,
   input logic track_en,
   input logic pwr_down
);
   int unsigned edges;
   int unsigned last_edges;
   logic        pd_at_start;

   always_ff @(negedge sclk or posedge cs_n or negedge rst_n) begin
      if (!rst_n)                   edges <= 0;
      else if (cs_n)                edges <= 0;
      else if (edges < FRAME_EDGES) edges <= edges + 1;
   end

   always_ff @(posedge cs_n or negedge rst_n) begin
      if (!rst_n) last_edges <= 0;
      else        last_edges <= edges;
   end

   always_ff @(negedge cs_n or negedge rst_n) begin
      if (!rst_n) pd_at_start <= 1'b0;
      else        pd_at_start <= pwr_down;
   end

   AST_IDLE_HIZ: assert property (@(negedge sclk) disable iff (!rst_n)
      cs_n |-> !dout_oe); // R1

   AST_QUIET_WHEN_OFF: assert property (@(negedge sclk) disable iff (!rst_n)
      !dout_oe |-> !dout); // R5

   AST_DRIVE_WINDOW: assert property (@(negedge sclk) disable iff (!rst_n)
      (!cs_n && edges < FRAME_EDGES) |-> dout_oe); // R4

   AST_HIZ_AT_END: assert property (@(negedge sclk) disable iff (!rst_n)
      (!cs_n && edges >= FRAME_EDGES) |-> !dout_oe); // R5

   AST_ABORT_SLEEP: assert property (@(negedge sclk) disable iff (!rst_n)
      (cs_n && last_edges >= ABORT_EDGE && last_edges < WAKE_EDGE) |-> pwr_down); // R7

   AST_EARLY_KEEP: assert property (@(negedge sclk) disable iff (!rst_n)
      (cs_n && last_edges < ABORT_EDGE) |-> (pwr_down == pd_at_start)); // R8

   AST_FULL_WAKE: assert property (@(negedge sclk) disable iff (!rst_n)
      (cs_n && last_edges >= WAKE_EDGE) |-> !pwr_down); // R9

   AST_NO_TRACK_ASLEEP: assert property (@(negedge sclk) disable iff (!rst_n)
      pwr_down |-> !track_en); // R10

   AST_HOLD_IN_FRAME: assert property (@(negedge sclk) disable iff (!rst_n)
      !cs_n |-> !track_en); // R10
endmodule

bind sar_serial_ctrl sar_serial_ctrl_chk #(
   .FRAME_EDGES(FRAME_EDGES), .ABORT_EDGE(ABORT_EDGE), .WAKE_EDGE(WAKE_EDGE)
) u_chk (
   .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .dout(dout), .dout_oe(dout_oe),
   .track_en(track_en), .pwr_down(pwr_down)
);

// File: tb/sar_serial_ctrl_test.sv
`timescale 1ns/1ps
module sar_serial_ctrl_test;
   localparam int RES_W = 12;

   logic             rst_n, sclk, cs_n, cmp_hi;
   logic             dout, dout_oe, track_en, pwr_down;
   logic [RES_W-1:0] trial_code, ain_code;
   int               n_chk = 0;
   int               n_bad = 0;
   bit               done  = 1'b0;
   bit               exp_pd;

   // Behavioural comparator: input code held at ain_code
   assign cmp_hi = (ain_code >= trial_code);

   initial sclk = 1'b0;
   always #4 sclk = ~sclk;

   sar_serial_ctrl uut (
      .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .cmp_hi(cmp_hi),
      .trial_code(trial_code), .dout(dout), .dout_oe(dout_oe),
      .track_en(track_en), .pwr_down(pwr_down));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic bit next_pd(input int edges, input bit cur);
      if (edges < 2)       return cur;
      else if (edges < 10) return 1'b1;
      else                 return 1'b0;
   endfunction

   task automatic frame(input logic [RES_W-1:0] code, input int nclk, input bit data_ok);
      ain_code = code;
      @(negedge sclk); #1 cs_n = 1'b0; #1;
      chk(dout_oe === 1'b1 && dout === 1'b0, "R2", "leading zero {oe,dout}",
          {dout_oe, dout}, 2);
      for (int k = 1; k <= nclk; k++) begin
         @(negedge sclk); #2;
         if (k <= RES_W) begin
            if (data_ok)
               chk(dout_oe === 1'b1 && dout === code[RES_W-k], "R3", "data {oe,dout}",
                   {dout_oe, dout}, {1'b1, code[RES_W-k]});
         end else if (k <= RES_W + 2) begin
            chk(dout_oe === 1'b1 && dout === 1'b0, (nclk == 14 && k == 14) ? "R6" : "R4",
                "trailing zero {oe,dout}", {dout_oe, dout}, 2);
         end else begin
            chk(dout_oe === 1'b0 && dout === 1'b0, "R5", "end of frame {oe,dout}",
                {dout_oe, dout}, 0);
         end
      end
      #1 cs_n = 1'b1; #1;
      chk(dout_oe === 1'b0 && dout === 1'b0, "R1", "after release {oe,dout}",
          {dout_oe, dout}, 0);
   endtask

   task automatic expect_pd(input bit exp, input string req);
      @(negedge sclk); #2;
      chk(pwr_down === exp, req, "pwr_down", pwr_down, exp);
      chk(track_en === !exp, "R10", "track_en", track_en, !exp);
   endtask

   initial begin
      #1600000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; ain_code = '0;
      repeat (3) @(negedge sclk);
      #1 rst_n = 1'b1; #1;
      chk(dout_oe === 1'b0 && dout === 1'b0, "R1", "reset {oe,dout}", {dout_oe, dout}, 0);
      chk(pwr_down === 1'b0, "R1", "reset pwr_down", pwr_down, 0);
      chk(track_en === 1'b1, "R10", "reset track_en", track_en, 1);

      // Every code through a full sixteen-clock frame
      for (int c = 0; c < (1 << RES_W); c++) begin
         frame(RES_W'(c), 16, 1'b1);
         if (c % 512 == 0) expect_pd(1'b0, "R9");
      end

      // Fourteen-clock frames
      frame(12'hFFF, 14, 1'b1); expect_pd(1'b0, "R6");
      frame(12'hA5A, 14, 1'b1); expect_pd(1'b0, "R6");
      frame(12'h001, 14, 1'b1); expect_pd(1'b0, "R6");

      // Release after every edge count, from both power states
      for (int n = 0; n <= 16; n++) begin
         for (int s = 0; s < 2; s++) begin
            if (s == 1) begin
               frame(12'h000, 5, 1'b0);
               expect_pd(1'b1, "R7");
            end else begin
               frame(12'h000, 16, 1'b0);
               expect_pd(1'b0, "R9");
            end
            frame(12'h5A3, n, (s == 0));
            exp_pd = next_pd(n, (s == 1));
            expect_pd(exp_pd, (n < 2) ? "R8" : ((n < 10) ? "R7" : "R9"));
            if (s == 1 && n >= 10) begin
               frame(12'h3C6, 16, 1'b1);
               expect_pd(1'b0, "R9");
            end
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule